// File: doc/BRIEF.md
# Store-Load Ordering Violation Queue

This block tracks loads that ran ahead of an older store whose address was still unknown. Such a load may have read memory before the store wrote it, so it is recorded here. Each record holds a compressed physical address, a byte mask, an age tag and a validity bit. The load pipeline offers a load in its second stage. If the load qualifies, an internal free list hands it the lowest free slot.

When a store address resolves, the store is presented to the queue for one cycle. One cycle later the queue reports a per-entry violation vector. It also reports a per-stage violation vector for the loads still in flight in load-pipeline stages s1 and s2. A queued load counts only if it is younger than the store, its compressed address equals the store's, the byte masks overlap, and its per-entry cache status shows that it already holds data or is waiting on a miss refill. Picking the oldest violator is left to a separate selector that consumes the vector.

Entries are freed one at a time when their load commits, or all at once by a global flush.

Top module: `ldviol_queue`

## Requirements
- R1: After reset no entry is valid, `enq_ready` is 1, `enq_slot` is 0, and `viol_mask` and `pl_viol` are 0.
- R2: `enq_alloc` is high exactly when `enq_valid` and `enq_sta_pending` are high, `enq_kill` and `flush_all` are low, and the queue is not full.
- R3: `enq_slot` is the lowest-numbered entry that is not valid, so that successive allocations into an empty queue take entries 0, 1, 2 and onward.
- R4: When all entries are valid, `enq_ready` is low and an offered load allocates nothing.
- R5: An allocated entry becomes valid, with its age, at the clock edge that ends the allocation cycle. Its mask and address are written one edge later. A store presented in the cycle right after the allocation cannot flag the entry; a store presented one cycle after that can.
- R6: The stored 24-bit address keeps physical bits 11:0 unchanged. Bit 12+k is pa[12+k] ^ pa[24+k] ^ pa[36+k] for k = 0..11 (48-bit address). Matching uses equality of these compressed values, so aliases that fold to the same value also match.
- R7: A queued load matches a store only if their 8-bit byte masks have at least one set bit in common.
- R8: An age is 7 bits: bit 6 is a wrap flag and bits 5:0 are an index. A load is younger than a store when the flags are equal and the load index is greater, or when the flags differ and the load index is smaller. Equal ages are not younger.
- R9: Entry i is flagged only if `ent_data_ok[i]` or `ent_miss_wait[i]` is high in the store's cycle.
- R10: `viol_mask[i]` is high in the cycle after a cycle with `st_valid` high exactly when entry i is valid and satisfies R6 to R9 against that store. After a cycle without `st_valid`, `viol_mask` is 0.
- R11: `pl_viol[k]` is high in the cycle after a store exactly when in-flight load k is valid, younger than the store and matches it under R6 and R7. No cache-status condition applies to in-flight loads.
- R12: `ent_release[i]` or `flush_all` clears entry i at the next edge and frees its slot. A freed entry never flags, and a mask write still pending for a freed slot is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Load offered from load stage 2 |
| enq_sta_pending | input | 1 | An older store still has an unresolved address |
| enq_kill | input | 1 | The offered load is being flushed |
| enq_paddr | input | 48 | Physical address of the offered load |
| enq_mask | input | 8 | Byte mask of the offered load |
| enq_age | input | 7 | Age of the offered load (wrap flag in bit 6) |
| enq_ready | output | 1 | Queue has a free entry |
| enq_alloc | output | 1 | Offered load is written this cycle |
| enq_slot | output | 5 | Entry chosen by the free list |
| ent_data_ok | input | 32 | Per entry: load already holds its data |
| ent_miss_wait | input | 32 | Per entry: load waits on a miss refill |
| ent_release | input | 32 | Per entry: free this entry |
| flush_all | input | 1 | Free every entry |
| st_valid | input | 1 | Store address check request |
| st_paddr | input | 48 | Store physical address |
| st_mask | input | 8 | Store byte mask |
| st_age | input | 7 | Store age |
| pl_valid | input | 2 | In-flight load valid, stages s1 and s2 |
| pl_paddr | input | 2x48 | In-flight load addresses |
| pl_mask | input | 2x8 | In-flight load byte masks |
| pl_age | input | 2x7 | In-flight load ages |
| viol_mask | output | 32 | Per-entry violation, one cycle after the store |
| pl_viol | output | 2 | In-flight load violation, one cycle after the store |

## Verification
The queue is filled to all 32 entries with distinct addresses and ages. A store aimed at each entry in turn confirms that exactly one bit fires and that the slot-to-entry mapping is right. Further stores at one entry separate the individual gates:
- ages that straddle, equal and wrap across the load's age test the age comparison;
- disjoint and single-byte masks test the mask overlap;
- addresses that fold to the same or a different compressed value test address compression;
- data-ready, miss and neither status patterns test the cache-status gate.

Release, flush and a store issued right after an allocation expose the timing of slot reuse and of the delayed mask write. In-flight loads that are younger or older than the store check the pipeline comparison on its own.

// File: rtl/ldviol_pkg.sv
package ldviol_pkg;

    localparam int AGE_IDX_W = 6;

    typedef struct packed {
        logic                 wrap;
        logic [AGE_IDX_W-1:0] idx;
    } age_t;

    // true when age ld lies after age st in program order
    function automatic logic is_younger(input age_t ld, input age_t st);
        if (ld.wrap == st.wrap) begin
            return ld.idx > st.idx;
        end
        return ld.idx < st.idx;
    endfunction

endpackage

// File: rtl/ldviol_hash.sv
module ldviol_hash #(
    parameter int PADDR_W = 48,
    parameter int HASH_W  = 24,
    parameter int PGOFF_W = 12
) (
    input  logic [PADDR_W-1:0] paddr,
    output logic [HASH_W-1:0]  hash
);
    localparam int FOLD_W = HASH_W - PGOFF_W;

    // page offset kept; upper bits folded onto the bits above it
    always_comb begin
        hash = paddr[HASH_W-1:0];
        for (int b = HASH_W; b < PADDR_W; b++) begin
            hash[PGOFF_W + ((b - HASH_W) % FOLD_W)] ^= paddr[b];
        end
    end
endmodule

// File: rtl/ldviol_freelist.sv
module ldviol_freelist #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = 5
) (
    input  logic [ENTRIES-1:0] busy,
    output logic [IDX_W-1:0]   slot,
    output logic               full
);
    logic found;

    always_comb begin
        slot  = '0;
        found = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!busy[i] && !found) begin
                slot  = IDX_W'(i);
                found = 1'b1;
            end
        end
        full = &busy;
    end
endmodule

// File: rtl/ldviol_match.sv
module ldviol_match
    import ldviol_pkg::*;
#(
    parameter int N      = 32,
    parameter int HASH_W = 24,
    parameter int MASK_W = 8
) (
    input  logic [N-1:0]      cand_valid,
    input  logic [N-1:0]      cand_elig,
    input  logic [HASH_W-1:0] cand_hash [N],
    input  logic [MASK_W-1:0] cand_mask [N],
    input  age_t              cand_age  [N],
    input  logic [HASH_W-1:0] st_hash,
    input  logic [MASK_W-1:0] st_mask,
    input  age_t              st_age,
    output logic [N-1:0]      hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = cand_valid[g] & cand_elig[g]
                      & (cand_hash[g] == st_hash)
                      & (|(cand_mask[g] & st_mask))
                      & is_younger(cand_age[g], st_age);
    end
endmodule

// File: rtl/ldviol_queue.sv
module ldviol_queue
    import ldviol_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int PADDR_W = 48,
    parameter int HASH_W  = 24,
    parameter int PGOFF_W = 12,
    parameter int MASK_W  = 8,
    parameter int PIPE_N  = 2,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int AGE_W  = AGE_IDX_W + 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            enq_valid,
    input  logic                            enq_sta_pending,
    input  logic                            enq_kill,
    input  logic [PADDR_W-1:0]              enq_paddr,
    input  logic [MASK_W-1:0]               enq_mask,
    input  logic [AGE_W-1:0]                enq_age,
    output logic                            enq_ready,
    output logic                            enq_alloc,
    output logic [IDX_W-1:0]                enq_slot,
    input  logic [ENTRIES-1:0]              ent_data_ok,
    input  logic [ENTRIES-1:0]              ent_miss_wait,
    input  logic [ENTRIES-1:0]              ent_release,
    input  logic                            flush_all,
    input  logic                            st_valid,
    input  logic [PADDR_W-1:0]              st_paddr,
    input  logic [MASK_W-1:0]               st_mask,
    input  logic [AGE_W-1:0]                st_age,
    input  logic [PIPE_N-1:0]               pl_valid,
    input  logic [PIPE_N-1:0][PADDR_W-1:0]  pl_paddr,
    input  logic [PIPE_N-1:0][MASK_W-1:0]   pl_mask,
    input  logic [PIPE_N-1:0][AGE_W-1:0]    pl_age,
    output logic [ENTRIES-1:0]              viol_mask,
    output logic [PIPE_N-1:0]               pl_viol
);
    // entry storage
    logic [ENTRIES-1:0] ent_valid;
    logic [HASH_W-1:0]  ent_hash [ENTRIES];
    logic [MASK_W-1:0]  ent_mask [ENTRIES];
    age_t               ent_age  [ENTRIES];

    // second-phase write of mask and address
    logic               pend_v;
    logic [IDX_W-1:0]   pend_slot;
    logic [HASH_W-1:0]  pend_hash;
    logic [MASK_W-1:0]  pend_mask;

    logic               q_full;
    logic [HASH_W-1:0]  enq_hash;
    logic [HASH_W-1:0]  st_hash;
    logic [ENTRIES-1:0] ent_hit;
    logic [ENTRIES-1:0] ent_elig;
    logic [PIPE_N-1:0]  pl_hit;
    logic               pend_drop;

    ldviol_freelist #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_free (
        .busy (ent_valid),
        .slot (enq_slot),
        .full (q_full)
    );

    ldviol_hash #(.PADDR_W(PADDR_W), .HASH_W(HASH_W), .PGOFF_W(PGOFF_W)) u_hash_enq (
        .paddr (enq_paddr),
        .hash  (enq_hash)
    );

    ldviol_hash #(.PADDR_W(PADDR_W), .HASH_W(HASH_W), .PGOFF_W(PGOFF_W)) u_hash_st (
        .paddr (st_paddr),
        .hash  (st_hash)
    );

    assign enq_ready = !q_full;
    assign enq_alloc = enq_valid && enq_sta_pending && !enq_kill && !flush_all && !q_full;
    assign ent_elig  = ent_data_ok | ent_miss_wait;
    assign pend_drop = flush_all || ent_release[pend_slot];

    ldviol_match #(.N(ENTRIES), .HASH_W(HASH_W), .MASK_W(MASK_W)) u_match_q (
        .cand_valid (ent_valid),
        .cand_elig  (ent_elig),
        .cand_hash  (ent_hash),
        .cand_mask  (ent_mask),
        .cand_age   (ent_age),
        .st_hash    (st_hash),
        .st_mask    (st_mask),
        .st_age     (age_t'(st_age)),
        .hit        (ent_hit)
    );

    // in-flight loads of the load pipeline
    logic [HASH_W-1:0] pl_hash_a [PIPE_N];
    logic [MASK_W-1:0] pl_mask_a [PIPE_N];
    age_t              pl_age_a  [PIPE_N];

    for (genvar k = 0; k < PIPE_N; k++) begin : g_pl
        ldviol_hash #(.PADDR_W(PADDR_W), .HASH_W(HASH_W), .PGOFF_W(PGOFF_W)) u_hash_pl (
            .paddr (pl_paddr[k]),
            .hash  (pl_hash_a[k])
        );
        assign pl_mask_a[k] = pl_mask[k];
        assign pl_age_a[k]  = age_t'(pl_age[k]);
    end

    ldviol_match #(.N(PIPE_N), .HASH_W(HASH_W), .MASK_W(MASK_W)) u_match_pl (
        .cand_valid (pl_valid),
        .cand_elig  ({PIPE_N{1'b1}}),
        .cand_hash  (pl_hash_a),
        .cand_mask  (pl_mask_a),
        .cand_age   (pl_age_a),
        .st_hash    (st_hash),
        .st_mask    (st_mask),
        .st_age     (age_t'(st_age)),
        .hit        (pl_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_valid <= '0;
            pend_v    <= 1'b0;
            pend_slot <= '0;
            pend_hash <= '0;
            pend_mask <= '0;
            viol_mask <= '0;
            pl_viol   <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                ent_hash[i] <= '0;
                ent_mask[i] <= '0;
                ent_age[i]  <= '0;
            end
        end else begin
            pend_v    <= enq_alloc;
            pend_slot <= enq_slot;
            pend_hash <= enq_hash;
            pend_mask <= enq_mask;

            for (int i = 0; i < ENTRIES; i++) begin
                if (flush_all || ent_release[i]) begin
                    ent_valid[i] <= 1'b0;
                end
            end

            if (enq_alloc) begin
                ent_valid[enq_slot] <= 1'b1;
                ent_age[enq_slot]   <= age_t'(enq_age);
                ent_mask[enq_slot]  <= '0;
            end

            if (pend_v && !pend_drop) begin
                ent_mask[pend_slot] <= pend_mask;
                ent_hash[pend_slot] <= pend_hash;
            end

            viol_mask <= st_valid ? ent_hit : '0;
            pl_viol   <= st_valid ? pl_hit  : '0;
        end
    end
endmodule

// File: rtl/ldviol_queue_chk.sv
module ldviol_queue_chk #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = 5,
    parameter int PIPE_N  = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               enq_ready,
    input logic               enq_alloc,
    input logic [IDX_W-1:0]   enq_slot,
    input logic [ENTRIES-1:0] ent_valid,
    input logic [ENTRIES-1:0] ent_release,
    input logic [ENTRIES-1:0] ent_data_ok,
    input logic [ENTRIES-1:0] ent_miss_wait,
    input logic               flush_all,
    input logic               st_valid,
    input logic [ENTRIES-1:0] viol_mask,
    input logic [PIPE_N-1:0]  pl_viol
);
    a_r4_full_blocks: assert property (@(posedge clk) disable iff (rst)
        !enq_ready |-> !enq_alloc);

    a_r3_slot_free: assert property (@(posedge clk) disable iff (rst)
        enq_alloc |-> !ent_valid[enq_slot]);

    a_r5_valid_next: assert property (@(posedge clk) disable iff (rst)
        enq_alloc |=> ent_valid[$past(enq_slot)]);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !st_valid |=> (viol_mask == '0 && pl_viol == '0));

    a_r12_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> ent_valid == '0);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        a_r9_status_gate: assert property (@(posedge clk) disable iff (rst)
            (st_valid && !ent_data_ok[g] && !ent_miss_wait[g]) |=> !viol_mask[g]);

        a_r12_release_clears: assert property (@(posedge clk) disable iff (rst)
            (ent_release[g] && !(enq_alloc && enq_slot == IDX_W'(g))) |=> !ent_valid[g]);
    end
endmodule

bind ldviol_queue ldviol_queue_chk #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W),
    .PIPE_N  (PIPE_N)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .enq_ready     (enq_ready),
    .enq_alloc     (enq_alloc),
    .enq_slot      (enq_slot),
    .ent_valid     (ent_valid),
    .ent_release   (ent_release),
    .ent_data_ok   (ent_data_ok),
    .ent_miss_wait (ent_miss_wait),
    .flush_all     (flush_all),
    .st_valid      (st_valid),
    .viol_mask     (viol_mask),
    .pl_viol       (pl_viol)
);

// File: tb/ldviol_queue_test.sv
module ldviol_queue_test;
    localparam int CLK_P = 10;
    localparam int N     = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic              enq_valid, enq_sta_pending, enq_kill;
    logic [47:0]       enq_paddr;
    logic [7:0]        enq_mask;
    logic [6:0]        enq_age;
    logic              enq_ready, enq_alloc;
    logic [4:0]        enq_slot;
    logic [N-1:0]      ent_data_ok, ent_miss_wait, ent_release;
    logic              flush_all;
    logic              st_valid;
    logic [47:0]       st_paddr;
    logic [7:0]        st_mask;
    logic [6:0]        st_age;
    logic [1:0]        pl_valid;
    logic [1:0][47:0]  pl_paddr;
    logic [1:0][7:0]   pl_mask;
    logic [1:0][6:0]   pl_age;
    logic [N-1:0]      viol_mask;
    logic [1:0]        pl_viol;

    int checks = 0;
    int errs   = 0;

    // bench model of the queue contents
    bit          m_valid [N];
    bit          m_live  [N];
    logic [47:0] m_pa    [N];
    logic [7:0]  m_mask  [N];
    logic [6:0]  m_age   [N];
    int          pend_idx = -1;

    ldviol_queue uut (
        .clk, .rst, .enq_valid, .enq_sta_pending, .enq_kill, .enq_paddr, .enq_mask,
        .enq_age, .enq_ready, .enq_alloc, .enq_slot, .ent_data_ok, .ent_miss_wait,
        .ent_release, .flush_all, .st_valid, .st_paddr, .st_mask, .st_age,
        .pl_valid, .pl_paddr, .pl_mask, .pl_age, .viol_mask, .pl_viol
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [23:0] bhash(input logic [47:0] pa);
        logic [23:0] h;
        h = pa[23:0];
        h[23:12] = h[23:12] ^ pa[35:24] ^ pa[47:36];
        return h;
    endfunction

    function automatic bit byoung(input logic [6:0] l, input logic [6:0] s);
        if (l[6] == s[6]) return l[5:0] > s[5:0];
        return l[5:0] < s[5:0];
    endfunction

    function automatic logic [47:0] pa_of(input int i);
        return 48'hA5_0000_0040 | (48'(i) << 12);
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        if (pend_idx >= 0) begin
            m_live[pend_idx] = 1'b1;
            pend_idx = -1;
        end
    endtask

    function automatic int model_slot();
        for (int j = 0; j < N; j++) if (!m_valid[j]) return j;
        return 0;
    endfunction

    task automatic enq_do(input logic [47:0] pa, input logic [7:0] m, input logic [6:0] a);
        int s;
        s = model_slot();
        enq_valid = 1; enq_sta_pending = 1; enq_kill = 0;
        enq_paddr = pa; enq_mask = m; enq_age = a;
        #1;
        check("R3 slot", 64'(enq_slot), 64'(s));
        check("R2 alloc", 64'(enq_alloc), 64'd1);
        step();
        enq_valid = 0;
        m_valid[s] = 1; m_live[s] = 0; m_pa[s] = pa; m_mask[s] = m; m_age[s] = a;
        pend_idx = s;
    endtask

    task automatic store_chk(input string req, input logic [47:0] pa, input logic [7:0] m,
                             input logic [6:0] a);
        logic [N-1:0] exp;
        logic [1:0]   pexp;
        st_paddr = pa; st_mask = m; st_age = a; st_valid = 1;
        exp = '0;
        for (int j = 0; j < N; j++) begin
            if (m_valid[j] && m_live[j] && bhash(m_pa[j]) == bhash(pa) && |(m_mask[j] & m)
                && byoung(m_age[j], a) && (ent_data_ok[j] || ent_miss_wait[j]))
                exp[j] = 1'b1;
        end
        pexp = '0;
        for (int k = 0; k < 2; k++) begin
            if (pl_valid[k] && bhash(pl_paddr[k]) == bhash(pa) && |(pl_mask[k] & m)
                && byoung(pl_age[k], a))
                pexp[k] = 1'b1;
        end
        step();
        st_valid = 0;
        check(req, 64'(viol_mask), 64'(exp));
        check(req, 64'(pl_viol), 64'(pexp));
    endtask

    task automatic release_vec(input logic [N-1:0] v);
        ent_release = v;
        step();
        ent_release = '0;
        for (int j = 0; j < N; j++) if (v[j]) begin m_valid[j] = 0; m_live[j] = 0; end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst = 1; enq_valid = 0; enq_sta_pending = 0; enq_kill = 0;
        enq_paddr = '0; enq_mask = '0; enq_age = '0;
        ent_data_ok = '1; ent_miss_wait = '0; ent_release = '0; flush_all = 0;
        st_valid = 0; st_paddr = '0; st_mask = '0; st_age = '0;
        pl_valid = '0; pl_paddr = '0; pl_mask = '0; pl_age = '0;
        for (int j = 0; j < N; j++) begin m_valid[j] = 0; m_live[j] = 0; end
        repeat (3) step();
        rst = 0;
        step();

        // R1 reset state
        check("R1 ready", 64'(enq_ready), 64'd1);
        check("R1 slot", 64'(enq_slot), 64'd0);
        check("R1 viol", 64'(viol_mask), 64'd0);
        check("R1 plviol", 64'(pl_viol), 64'd0);

        // R2 enqueue condition sweep
        enq_paddr = pa_of(0); enq_mask = 8'h0F; enq_age = 7'd1;
        for (int c = 0; c < 16; c++) begin
            enq_valid = c[0]; enq_sta_pending = c[1]; enq_kill = c[2]; flush_all = c[3];
            #1;
            check("R2 cond", 64'(enq_alloc), 64'(c == 3));
        end
        flush_all = 1; enq_valid = 1; enq_sta_pending = 1; enq_kill = 0;
        step();
        flush_all = 0; enq_valid = 0;
        check("R2 flush blocks alloc", 64'(enq_slot), 64'd0);

        // R3 fill all entries back to back
        for (int i = 0; i < N; i++) enq_do(pa_of(i), (i % 2 == 0) ? 8'h0F : 8'hF0, 7'(10 + i));
        step();

        // R4 full queue refuses
        check("R4 ready low", 64'(enq_ready), 64'd0);
        enq_valid = 1; enq_sta_pending = 1; enq_kill = 0; enq_paddr = pa_of(3);
        #1;
        check("R4 no alloc", 64'(enq_alloc), 64'd0);
        step();
        enq_valid = 0;
        check("R4 still full", 64'(enq_ready), 64'd0);

        // R6 / R10 exact address per entry
        for (int i = 0; i < N; i++) store_chk("R10 per entry", pa_of(i), 8'hFF, 7'd5);
        step();
        check("R10 idle quiet", 64'(viol_mask), 64'd0);

        // R8 age boundaries at entry 20 (age 30)
        store_chk("R8 older store", pa_of(20), 8'hFF, 7'd29);
        store_chk("R8 equal age", pa_of(20), 8'hFF, 7'd30);
        store_chk("R8 younger store", pa_of(20), 8'hFF, 7'd31);
        store_chk("R8 wrap hit", pa_of(20), 8'hFF, {1'b1, 6'd31});
        store_chk("R8 wrap miss", pa_of(20), 8'hFF, {1'b1, 6'd30});

        // R7 mask overlap at entry 4 (mask 0F)
        store_chk("R7 disjoint", pa_of(4), 8'hF0, 7'd0);
        store_chk("R7 one byte", pa_of(4), 8'h08, 7'd0);

        // R6 address folding at entry 7
        store_chk("R6 alias 24", pa_of(7) ^ (48'h1 << 24) ^ (48'h1 << 12), 8'hFF, 7'd0);
        store_chk("R6 alias 36", pa_of(7) ^ (48'h1 << 36) ^ (48'h1 << 24), 8'hFF, 7'd0);
        store_chk("R6 differ 12", pa_of(7) ^ (48'h1 << 12), 8'hFF, 7'd0);
        store_chk("R6 differ offset", pa_of(7) ^ 48'h1, 8'hFF, 7'd0);

        // R9 cache status gate
        for (int i = 0; i < 6; i++) begin
            ent_data_ok = '0; ent_miss_wait = '0;
            ent_data_ok[i]   = (i % 3 == 1);
            ent_miss_wait[i] = (i % 3 == 2);
            store_chk("R9 status", pa_of(i), 8'hFF, 7'd0);
        end
        ent_data_ok = '1; ent_miss_wait = '0;

        // R11 in-flight loads
        pl_valid = 2'b11;
        pl_paddr[0] = 48'h77_0000_1100; pl_mask[0] = 8'h01; pl_age[0] = 7'd50;
        pl_paddr[1] = 48'h77_0000_1100; pl_mask[1] = 8'h01; pl_age[1] = 7'd2;
        store_chk("R11 young vs old", 48'h77_0000_1100, 8'h03, 7'd40);
        pl_mask[0] = 8'h02; pl_age[1] = 7'd45;
        store_chk("R11 mask and age", 48'h77_0000_1100, 8'h01, 7'd40);
        pl_valid = 2'b00;
        store_chk("R11 invalid", 48'h77_0000_1100, 8'h01, 7'd40);

        // R12 release single entries
        release_vec((32'h1 << 5) | (32'h1 << 9));
        check("R12 ready after release", 64'(enq_ready), 64'd1);
        check("R12 freed slot", 64'(enq_slot), 64'd5);
        store_chk("R12 released no hit", pa_of(5), 8'hFF, 7'd0);
        store_chk("R12 neighbour hit", pa_of(6), 8'hFF, 7'd0);

        // R12 release while the mask write is pending
        enq_do(pa_of(40), 8'hFF, 7'd60);
        release_vec(32'h1 << 5);
        enq_do(pa_of(41), 8'hFF, 7'd61);
        step();
        store_chk("R12 dropped write", pa_of(40), 8'hFF, 7'd0);

        // R12 global flush
        flush_all = 1;
        step();
        flush_all = 0;
        for (int j = 0; j < N; j++) begin m_valid[j] = 0; m_live[j] = 0; end
        check("R12 flush ready", 64'(enq_ready), 64'd1);
        check("R12 flush slot", 64'(enq_slot), 64'd0);
        store_chk("R12 flushed no hit", pa_of(0), 8'hFF, 7'd0);

        // R5 two-phase write timing
        enq_do(48'h12_3456_7000, 8'h0C, 7'd20);
        store_chk("R5 too early", 48'h12_3456_7000, 8'h04, 7'd3);
        store_chk("R5 now visible", 48'h12_3456_7000, 8'h04, 7'd3);
        check("R5 slot advanced", 64'(enq_slot), 64'd1);

        summary();
    end
endmodule